// File: doc/BRIEF.md
# UART Register Front End

This block sits between a 32-bit memory-mapped bus and the serializer and deserializer of a UART. It decodes three word registers: a combined data register that carries both the transmit and the receive byte with their handshake flags, a control register for the interface mode and the two flow-control overrides, and a baud configuration register whose prescale and fractional-step fields are passed straight to the bit-timing logic.

Software launches a byte by writing it with the transmit-ready flag position set, and polls that flag until the holding register is free again. The serializer sees a request while a byte is held and flow control allows it, and pulses a take strobe to empty the holding register. Received bytes are parked in a one-byte holding register; software reads them together with a valid flag and writes a one to the valid position to discard them. Reads have no side effects.

Top module: `serport_regs`

## Requirements
- R1: After reset the data word reads 0x0000_0200 (bit 9 set, bit 8 clear, byte zero), the control and baud words read zero, `ser_req_o` is low and `des_ready_o` is high.
- R2: Word offset 0x00 is data, 0x04 is control and 0x08 is baud; any other offset, or an address with bits 1:0 non-zero, reads zero and a write to it changes nothing.
- R3: A data write with bit 9 set while bit 9 reads 1 places bits 7:0 on `ser_byte_o` from the next cycle, and bit 9 then reads 0.
- R4: A data write with bit 9 clear starts no transmission, and a data write with bit 9 set while bit 9 reads 0 leaves the held byte unchanged.
- R5: A `ser_take_i` pulse while `ser_req_o` is high empties the holding register: in the next cycle `ser_req_o` is low and bit 9 reads 1.
- R6: A `des_strobe_i` pulse with no byte waiting captures `des_byte_i`; from the next cycle bit 8 reads 1 and bits 7:0 return that byte.
- R7: A data write with bit 8 set discards the waiting byte (bit 8 and bits 7:0 then read 0); a data write with bit 8 clear leaves the waiting byte and bit 8 unchanged.
- R8: A `des_strobe_i` pulse while a byte is waiting and no discard is written keeps the waiting byte and sets an internal overrun flag.
- R9: Control bits 3:2 drive `if_mode_o` (1 selects terminal-side, 2 selects modem-side wiring); control bits 7 and 8 are stored; all other control bits read zero.
- R10: `ser_req_o` is high exactly when a byte is held and either `peer_cts_i` is high or control bit 7 is set.
- R11: `des_ready_o` is high when no byte is waiting or control bit 8 is set, and low otherwise.
- R12: Baud bits 15:0 drive `baud_step_o` and bits 27:16 drive `baud_scale_o`; bits 31:28 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write enable for the access |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| peer_cts_i | input | 1 | Remote side ready to receive |
| ser_req_o | output | 1 | Byte available to the serializer |
| ser_byte_o | output | 8 | Held transmit byte |
| ser_take_i | input | 1 | Serializer has taken the held byte |
| des_strobe_i | input | 1 | Deserializer delivers a byte |
| des_byte_i | input | 8 | Byte from the deserializer |
| des_ready_o | output | 1 | Receive side can accept a byte |
| if_mode_o | output | 2 | Interface mode from control bits 3:2 |
| baud_scale_o | output | SCALE_W | Baud prescale field |
| baud_step_o | output | STEP_W | Baud fractional step field |

## Verification
The assertions assume that the serializer only pulses `ser_take_i` while `ser_req_o` is high, and this assumption is itself checked; the deserializer may strobe at any time, including while a byte is still waiting, since that is the overrun case. The bench pulses the take strobe only after observing the request, drives every input on the falling edge, and sweeps all 256 byte values through both holding registers under every combination of flow-control input and override, with deliberate strobes into a full receive holder.

// File: rtl/serport_pkg.sv
package serport_pkg;

    localparam int BUS_W      = 32;
    localparam int BYTE_W     = 8;

    // word indexes of the three registers
    localparam int WORD_DATA  = 0;
    localparam int WORD_CTRL  = 1;
    localparam int WORD_BAUD  = 2;

    // data word flag positions
    localparam int RXV_BIT    = 8;
    localparam int TXR_BIT    = 9;

    // control word field positions
    localparam int MODE_LSB   = 2;
    localparam int MODE_W     = 2;
    localparam int FTX_BIT    = 7;
    localparam int FRX_BIT    = 8;

    // baud word field positions
    localparam int STEP_LSB   = 0;
    localparam int SCALE_LSB  = 16;

    localparam logic [BUS_W-1:0] CTRL_MASK =
        (BUS_W'((1 << MODE_W) - 1) << MODE_LSB) |
        (BUS_W'(1) << FTX_BIT) |
        (BUS_W'(1) << FRX_BIT);

endpackage

// File: rtl/serport_txhold.sv
module serport_txhold #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              take,
    input  logic              flow_ok,
    output logic              full,
    output logic [BYTE_W-1:0] hold_byte,
    output logic              req
);

    typedef struct packed {
        logic              full;
        logic [BYTE_W-1:0] data;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take && st_q.full) begin
            st_d.full = 1'b0;
        end else if (load && !st_q.full) begin
            st_d.full = 1'b1;
            st_d.data = load_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full      = st_q.full;
    assign hold_byte = st_q.data;
    assign req       = st_q.full & flow_ok;

endmodule

// File: rtl/serport_rxhold.sv
module serport_rxhold #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              ack,
    output logic              full,
    output logic [BYTE_W-1:0] hold_byte,
    output logic              overrun
);

    typedef struct packed {
        logic              full;
        logic              ovr;
        logic [BYTE_W-1:0] data;
    } rx_st_t;

    rx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ack) begin
            st_d.full = 1'b0;
            st_d.ovr  = 1'b0;
        end
        if (strobe) begin
            if (st_q.full && !ack) begin
                st_d.ovr  = 1'b1;
            end else begin
                st_d.full = 1'b1;
                st_d.data = in_byte;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full      = st_q.full;
    assign hold_byte = st_q.data;
    assign overrun   = st_q.ovr;

endmodule

// File: rtl/serport_cfg.sv
module serport_cfg
    import serport_pkg::*;
#(
    parameter int SCALE_W = 12,
    parameter int STEP_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic             baud_we,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] ctrl_word,
    output logic [BUS_W-1:0] baud_word
);

    localparam logic [BUS_W-1:0] BAUD_MASK =
        (BUS_W'((64'd1 << SCALE_W) - 1) << SCALE_LSB) |
        (BUS_W'((64'd1 << STEP_W) - 1) << STEP_LSB);

    typedef struct packed {
        logic [BUS_W-1:0] ctrl;
        logic [BUS_W-1:0] baud;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctrl_we) begin
            st_d.ctrl = wdata & CTRL_MASK;
        end
        if (baud_we) begin
            st_d.baud = wdata & BAUD_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_word = st_q.ctrl;
    assign baud_word = st_q.baud;

endmodule

// File: rtl/serport_regs.sv
module serport_regs
    import serport_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int SCALE_W = 12,
    parameter int STEP_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               peer_cts_i,
    output logic               ser_req_o,
    output logic [7:0]         ser_byte_o,
    input  logic               ser_take_i,
    input  logic               des_strobe_i,
    input  logic [7:0]         des_byte_i,
    output logic               des_ready_o,
    output logic [1:0]         if_mode_o,
    output logic [SCALE_W-1:0] baud_scale_o,
    output logic [STEP_W-1:0]  baud_step_o
);

    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] word_idx;
    logic              aligned;
    logic              hit_data, hit_ctrl, hit_baud;
    logic              wr_data, wr_ctrl, wr_baud;
    logic              tx_load, rx_ack;
    logic              tx_full, rx_full, rx_overrun;
    logic [7:0]        rx_byte;
    logic [BUS_W-1:0]  ctrl_word, baud_word;
    logic              force_tx, force_rx;

    // address decode
    assign word_idx = bus_addr[ADDR_W-1:2];
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign hit_data = aligned && (word_idx == WIDX_W'(WORD_DATA));
    assign hit_ctrl = aligned && (word_idx == WIDX_W'(WORD_CTRL));
    assign hit_baud = aligned && (word_idx == WIDX_W'(WORD_BAUD));

    assign wr_data  = bus_sel && bus_we && hit_data;
    assign wr_ctrl  = bus_sel && bus_we && hit_ctrl;
    assign wr_baud  = bus_sel && bus_we && hit_baud;

    assign tx_load  = wr_data && bus_wdata[TXR_BIT] && !tx_full;
    assign rx_ack   = wr_data && bus_wdata[RXV_BIT];

    assign force_tx = ctrl_word[FTX_BIT];
    assign force_rx = ctrl_word[FRX_BIT];

    serport_txhold #(.BYTE_W(BYTE_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tx_load),
        .load_byte (bus_wdata[BYTE_W-1:0]),
        .take      (ser_take_i),
        .flow_ok   (peer_cts_i | force_tx),
        .full      (tx_full),
        .hold_byte (ser_byte_o),
        .req       (ser_req_o)
    );

    serport_rxhold #(.BYTE_W(BYTE_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (des_strobe_i),
        .in_byte   (des_byte_i),
        .ack       (rx_ack),
        .full      (rx_full),
        .hold_byte (rx_byte),
        .overrun   (rx_overrun)
    );

    serport_cfg #(.SCALE_W(SCALE_W), .STEP_W(STEP_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_we   (wr_ctrl),
        .baud_we   (wr_baud),
        .wdata     (bus_wdata),
        .ctrl_word (ctrl_word),
        .baud_word (baud_word)
    );

    // read mux, no side effects
    always_comb begin
        bus_rdata = '0;
        if (hit_data) begin
            bus_rdata[TXR_BIT]      = !tx_full;
            bus_rdata[RXV_BIT]      = rx_full;
            bus_rdata[BYTE_W-1:0]   = rx_full ? rx_byte : '0;
        end else if (hit_ctrl) begin
            bus_rdata = ctrl_word;
        end else if (hit_baud) begin
            bus_rdata = baud_word;
        end
    end

    assign des_ready_o  = force_rx | !rx_full;
    assign if_mode_o    = ctrl_word[MODE_LSB +: MODE_W];
    assign baud_scale_o = baud_word[SCALE_LSB +: SCALE_W];
    assign baud_step_o  = baud_word[STEP_LSB +: STEP_W];

endmodule

// File: rtl/serport_regs_chk.sv
module serport_regs_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              ser_req_o,
    input logic              ser_take_i,
    input logic              des_strobe_i,
    input logic              des_ready_o,
    input logic              tx_full,
    input logic              rx_full,
    input logic [7:0]        rx_byte,
    input logic              rx_overrun,
    input logic              force_rx
);

    logic discard_wr;
    assign discard_wr = bus_sel && bus_we && (bus_addr == '0) && bus_wdata[8];

    assert_take_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ser_take_i |-> ser_req_o);

    assert_take_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ser_take_i |=> !tx_full);

    assert_req_needs_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ser_req_o |-> tx_full);

    assert_rx_keeps_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && des_strobe_i && !discard_wr) |=> (rx_full && rx_byte == $past(rx_byte)));

    assert_overrun_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && des_strobe_i && !discard_wr) |=> rx_overrun);

    assert_no_discard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !discard_wr) |=> rx_full);

    assert_discard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (discard_wr && !des_strobe_i) |=> !rx_full);

    assert_des_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !force_rx) |-> !des_ready_o);

endmodule

bind serport_regs serport_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .ser_req_o    (ser_req_o),
    .ser_take_i   (ser_take_i),
    .des_strobe_i (des_strobe_i),
    .des_ready_o  (des_ready_o),
    .tx_full      (tx_full),
    .rx_full      (rx_full),
    .rx_byte      (rx_byte),
    .rx_overrun   (rx_overrun),
    .force_rx     (force_rx)
);

// File: tb/serport_regs_bench.sv
module serport_regs_bench;

    localparam int ADDR_W = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel, bus_we;
    logic [ADDR_W-1:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        peer_cts_i, ser_req_o, ser_take_i;
    logic [7:0]  ser_byte_o, des_byte_i;
    logic        des_strobe_i, des_ready_o;
    logic [1:0]  if_mode_o;
    logic [11:0] baud_scale_o;
    logic [15:0] baud_step_o;

    int n_vec  = 0;
    int n_miss = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    serport_regs u_serport_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .peer_cts_i(peer_cts_i), .ser_req_o(ser_req_o), .ser_byte_o(ser_byte_o),
        .ser_take_i(ser_take_i), .des_strobe_i(des_strobe_i), .des_byte_i(des_byte_i),
        .des_ready_o(des_ready_o), .if_mode_o(if_mode_o),
        .baud_scale_o(baud_scale_o), .baud_step_o(baud_step_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_miss++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] v);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic take_pulse();
        ser_take_i = 1'b1;
        @(posedge clk); @(negedge clk);
        ser_take_i = 1'b0;
    endtask

    task automatic strobe(input logic [7:0] b);
        des_strobe_i = 1'b1; des_byte_i = b;
        @(posedge clk); @(negedge clk);
        des_strobe_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_miss++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; bus_sel = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
        peer_cts_i = 0; ser_take_i = 0; des_strobe_i = 0; des_byte_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'h0, v); chk("R1 data", v, 32'h200);
        rd(4'h4, v); chk("R1 ctrl", v, 32'h0);
        rd(4'h8, v); chk("R1 baud", v, 32'h0);
        chk("R1 req", 32'(ser_req_o), 0);
        chk("R1 des_ready", 32'(des_ready_o), 1);

        // R2 decode: unmapped and misaligned
        wr(4'hC, 32'hFFFF_FFFF); rd(4'hC, v); chk("R2 unmapped", v, 0);
        wr(4'h5, 32'hFFFF_FFFF); rd(4'h4, v); chk("R2 misaligned wr", v, 0);
        rd(4'h6, v); chk("R2 misaligned rd", v, 0);
        wr(4'h1, 32'h0000_03AA); chk("R2 misaligned data", 32'(ser_req_o), 0);
        rd(4'h0, v); chk("R2 data intact", v, 32'h200);

        // R9 control sweep
        for (int m = 0; m < 16; m++) begin
            logic [31:0] w;
            w = {m[3:0], 28'h0} | 32'(m[1:0]) << 2 | 32'(m[2]) << 7 | 32'(m[3]) << 8 | 32'h0000_0063;
            wr(4'h4, w);
            rd(4'h4, v);
            chk("R9 ctrl read", v, w & 32'h18C);
            chk("R9 mode", 32'(if_mode_o), (w >> 2) & 3);
        end
        wr(4'h4, 32'h0);

        // R12 baud patterns
        for (int k = 0; k < 16; k++) begin
            logic [31:0] w;
            w = 32'h9E37_79B9 * (k + 1);
            wr(4'h8, w);
            rd(4'h8, v);
            chk("R12 baud read", v, w & 32'h0FFF_FFFF);
            chk("R12 scale", 32'(baud_scale_o), (w >> 16) & 32'hFFF);
            chk("R12 step", 32'(baud_step_o), w & 32'hFFFF);
        end

        // transmit sweep over every byte, cts and override
        for (int f = 0; f < 2; f++) begin
            wr(4'h4, 32'(f) << 7);
            for (int b = 0; b < 256; b++) begin
                logic cts;
                cts = b[0] ^ b[3];
                peer_cts_i = cts;
                // R4 bit 9 clear does nothing
                wr(4'h0, 32'(b));
                rd(4'h0, v); chk("R4 no launch", v[9], 1);
                // R3 launch
                wr(4'h0, 32'h200 | 32'(b));
                rd(4'h0, v); chk("R3 busy flag", v[9], 0);
                chk("R3 byte", 32'(ser_byte_o), 32'(b));
                chk("R10 req", 32'(ser_req_o), 32'(cts | f[0]));
                // R4 write while busy ignored
                wr(4'h0, 32'h200 | 32'(~b[7:0]));
                chk("R4 byte kept", 32'(ser_byte_o), 32'(b));
                if (!ser_req_o) begin
                    peer_cts_i = 1'b1; #1;
                    chk("R10 cts raises req", 32'(ser_req_o), 1);
                end
                // R5 take
                take_pulse();
                chk("R5 req low", 32'(ser_req_o), 0);
                rd(4'h0, v); chk("R5 ready again", v[9], 1);
            end
        end
        wr(4'h4, 32'h0);
        peer_cts_i = 1'b0;

        // receive sweep over every byte
        for (int f = 0; f < 2; f++) begin
            wr(4'h4, 32'(f) << 8);
            for (int b = 0; b < 256; b++) begin
                strobe(8'(b));
                rd(4'h0, v); chk("R6 rx word", v, 32'h300 | 32'(b));
                chk("R11 des_ready", 32'(des_ready_o), 32'(f));
                wr(4'h0, 32'h0);
                rd(4'h0, v); chk("R7 no discard", v, 32'h300 | 32'(b));
                strobe(~8'(b));
                rd(4'h0, v); chk("R8 overrun keeps", v, 32'h300 | 32'(b));
                wr(4'h0, 32'h100);
                rd(4'h0, v); chk("R7 discard", v, 32'h200);
                chk("R11 ready empty", 32'(des_ready_o), 1);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

endmodule